// File: doc/BRIEF.md
# Extended-Data-Out DRAM Device Emulator

This block stands in for the memory device on the far side of an asynchronous DRAM controller under test. The controller's row strobe, column strobe, write enable, output enable and multiplexed address pins are all sampled on a fast system clock. The block detects strobe edges from one sample to the next. It decodes read, early-write, late-write and read-modify-write cycles against a small register array. The data bus is split into a data-in port, a data-out port and an output-enable flag, so that a board-level or testbench wrapper can build the tri-state pin from them.

A parameter selects the output behaviour. In extended-data-out mode, read data stays on the outputs after the column strobe returns high. In fast-page mode, the outputs turn off at that rising edge. In both modes, write acceptance depends on which of the write-enable and column-strobe falling edges comes later, and on the output enable at that moment. All strobes are active low. Every strobe edge takes effect at the first clock edge that samples it, and the data register follows one clock later.

Top module: `edo_dram_model`

## Requirements
- R1: After reset, `dout_en` is 0 and `dout` is 0.
- R2: The row is taken from `addr` at the clock edge that first sees `ras_n` low. The column is taken from `addr` at the edge that first sees `cas_n` low while `ras_n` was already low. The cell index is {row, column}, with the row in the upper bits.
- R3: A column-strobe fall with `we_n` high is a read. From the next sample on, `dout` carries the addressed cell, and `dout_en` is 1 while `oe_n` is low.
- R4: While `oe_n` is high, `dout_en` is 0 and `dout` is 0. When `oe_n` returns low during a held read, the same data is driven again.
- R5: With EDO_MODE=1, read data stays driven after `cas_n` rises, as long as `ras_n` stays low and `we_n` stays high.
- R6: With EDO_MODE=0, the outputs turn off at the clock edge that sees `cas_n` rise.
- R7: In both modes, the outputs turn off at the clock edge that sees `ras_n` high.
- R8: If `we_n` is already low, or falls in the same sample as `cas_n`, the cycle is an early write. The cell stores `din` as sampled at the column-strobe edge, and the outputs stay off whatever `oe_n` is.
- R9: If `we_n` falls while `cas_n` is low, `oe_n` is high and `ras_n` is low, the cycle is a late write. The latched column stores `din` as sampled at the write-enable edge, and the outputs are off afterwards.
- R10: A late write attempted with `oe_n` low stores nothing. The outputs keep driving the read data.
- R11: With EDO_MODE=1, a fall of `we_n` while `cas_n` is high turns the held outputs off.
- R12: Further column-strobe cycles within one row access address new columns of the same row (page mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(ROW_W,COL_W) | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | Data outputs driven |

## Verification
The write-enable and column-strobe falls can arrive in the same sample, and the block then has to decide between an early write and a late write. The bench drops both strobes in one step with `oe_n` low. It judges the outcome twice: the outputs must stay off during the cycle, and a later read must return the new data. A late-write decode would instead have kept the outputs on and stored nothing. A second instance in fast-page mode receives the same stimulus, so the column-strobe rise is judged in both modes on the same cycles.

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
  parameter int ROW_W    = 3,
  parameter int COL_W    = 3,
  parameter int DATA_W   = 8,
  parameter bit EDO_MODE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  input  logic [DATA_W-1:0]    din,
  output logic [DATA_W-1:0]    dout,
  output logic                 dout_en
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              ras_q, cas_q, we_q;
  logic              col_ok, drv;
  logic [DATA_W-1:0] dout_q;

  logic ras_fall, cas_rise, cas_fall_ok, we_fall;
  logic early_wr, rd_cyc, late_try, late_ok;
  logic [IDX_W-1:0] cas_idx, late_idx;

  assign ras_fall    = ras_q & ~ras_n;
  assign cas_rise    = ~cas_q & cas_n;
  assign cas_fall_ok = cas_q & ~cas_n & ~ras_q & ~ras_n;
  assign we_fall     = we_q & ~we_n;
  assign early_wr    = cas_fall_ok & ~we_n;
  assign rd_cyc      = cas_fall_ok & we_n;
  assign late_try    = we_fall & ~cas_n & ~cas_q & ~ras_n & col_ok;
  assign late_ok     = late_try & oe_n;
  assign cas_idx     = {row_q, addr[COL_W-1:0]};
  assign late_idx    = {row_q, col_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      row_q  <= '0;
      col_q  <= '0;
      col_ok <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
      if (ras_fall) row_q <= addr[ROW_W-1:0];
      if (cas_fall_ok) col_q <= addr[COL_W-1:0];
      if (ras_n || cas_rise) col_ok <= 1'b0;
      else if (cas_fall_ok)  col_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (early_wr) begin
      mem[cas_idx] <= din;
    end else if (late_ok) begin
      mem[late_idx] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv    <= 1'b0;
      dout_q <= '0;
    end else if (ras_n || early_wr || late_ok) begin
      drv <= 1'b0;
    end else if (rd_cyc) begin
      drv    <= 1'b1;
      dout_q <= mem[cas_idx];
    end else if (cas_rise && !EDO_MODE) begin
      drv <= 1'b0;
    end else if (we_fall && cas_n) begin
      drv <= 1'b0;
    end
  end

  assign dout_en = drv & ~oe_n;
  assign dout    = dout_en ? dout_q : '0;

  assert_ras_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && $past(ras_n)) |-> !dout_en);
  assert_early_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    early_wr |=> !dout_en);
  assert_late_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    late_ok |=> (mem[$past(late_idx)] == $past(din)) && !drv);
  assert_late_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (late_try && !oe_n) |=> (dout_q == $past(dout_q)) && drv == $past(drv));
  assert_fpm_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!EDO_MODE && cas_rise) |=> !dout_en);
  assert_edo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (EDO_MODE && cas_rise && !ras_n && we_n && drv) |=> drv && $stable(dout_q));
endmodule

// File: tb/edo_dram_model_bench.sv
module edo_dram_model_bench;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, dout_f;
  logic dout_en, dout_en_f;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] ref_mem [64];

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  edo_dram_model #(.EDO_MODE(1'b1)) u_edo_dram_model (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));
  edo_dram_model #(.EDO_MODE(1'b0)) u_edo_dram_model_fpm (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout_f), .dout_en(dout_en_f));

  // {row, col, data}
  localparam logic [13:0] VEC [8] = '{
    {3'd0, 3'd0, 8'h11}, {3'd0, 3'd7, 8'hA5}, {3'd7, 3'd0, 8'h5A},
    {3'd7, 3'd7, 8'hFF}, {3'd3, 3'd4, 8'h3C}, {3'd4, 3'd3, 8'hC3},
    {3'd2, 3'd5, 8'h01}, {3'd5, 3'd2, 8'h80}};

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic open_row(logic [2:0] r); addr = r; ras_n = 1'b0; tick(); endtask
  task automatic cas_lo(logic [2:0] c); addr = c; cas_n = 1'b0; tick(); endtask
  task automatic cas_hi(); cas_n = 1'b1; tick(); endtask
  task automatic close_row(); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; tick(); endtask

  task automatic early_write(logic [2:0] r, logic [2:0] c, logic [DW-1:0] d);
    open_row(r);
    we_n = 1'b0; din = d;
    cas_lo(c);
    chk("R8 early write outputs off", dout_en, 0);
    ref_mem[{r, c}] = d;
    cas_hi();
    close_row();
  endtask

  task automatic read_back(string tag, logic [2:0] r, logic [2:0] c);
    open_row(r);
    cas_lo(c);
    chk(tag, {dout_en, dout}, {1'b1, ref_mem[{r, c}]});
    close_row();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = '0;
    tick(); tick();
    chk("R1 reset dout_en", dout_en, 0);
    chk("R1 reset dout", dout, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 8; i++) early_write(VEC[i][13:11], VEC[i][10:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) read_back("R2 R3 table read", VEC[i][13:11], VEC[i][10:8]);

    // EDO hold vs fast-page release, then OE gating
    open_row(3'd3); cas_lo(3'd4);
    cas_hi();
    chk("R5 EDO hold after CAS rise", {dout_en, dout}, {1'b1, 8'h3C});
    chk("R6 FPM off after CAS rise", {dout_en_f, dout_f}, 9'h0);
    oe_n = 1'b1; tick();
    chk("R4 OE high disables", {dout_en, dout}, 9'h0);
    oe_n = 1'b0; tick();
    chk("R4 OE low re-enables", {dout_en, dout}, {1'b1, 8'h3C});
    we_n = 1'b0; tick();
    chk("R11 WE fall with CAS high ends hold", dout_en, 0);
    close_row();

    // RAS rise while CAS still low
    open_row(3'd7); cas_lo(3'd7);
    chk("R3 read before RAS rise", {dout_en_f, dout_f}, {1'b1, 8'hFF});
    ras_n = 1'b1; tick();
    chk("R7 RAS high off EDO", dout_en, 0);
    chk("R7 RAS high off FPM", dout_en_f, 0);
    close_row();

    // page mode
    open_row(3'd0); cas_lo(3'd0);
    chk("R12 page first column", dout, 8'h11);
    cas_hi(); cas_lo(3'd7);
    chk("R12 page second column", {dout_en, dout}, {1'b1, 8'hA5});
    chk("R12 page second column FPM", {dout_en_f, dout_f}, {1'b1, 8'hA5});
    close_row();

    // late write accepted
    open_row(3'd6); cas_lo(3'd1);
    oe_n = 1'b1; tick();
    din = 8'h6B; we_n = 1'b0; tick();
    ref_mem[{3'd6, 3'd1}] = 8'h6B;
    din = 8'h00; oe_n = 1'b0; tick();
    chk("R9 late write outputs off", dout_en, 0);
    close_row();
    read_back("R9 late write stored", 3'd6, 3'd1);

    // late write refused with OE low
    open_row(3'd4); cas_lo(3'd3);
    din = 8'h99; we_n = 1'b0; tick();
    chk("R10 refused late write keeps data", {dout_en, dout}, {1'b1, 8'hC3});
    close_row();
    read_back("R10 refused late write stored nothing", 3'd4, 3'd3);

    // WE and CAS fall in the same sample, OE low
    open_row(3'd1);
    din = 8'h77; we_n = 1'b0; cas_n = 1'b0; addr = 3'd6; tick();
    chk("R8 coincident edges outputs off", dout_en, 0);
    ref_mem[{3'd1, 3'd6}] = 8'h77;
    close_row();
    read_back("R8 coincident edges stored", 3'd1, 3'd6);

    // early write with OE low
    open_row(3'd2); oe_n = 1'b0; we_n = 1'b0; din = 8'hE1; cas_lo(3'd2);
    tick();
    chk("R8 early write ignores OE", dout_en, 0);
    ref_mem[{3'd2, 3'd2}] = 8'hE1;
    close_row();
    read_back("R8 R2 early write addressed cell", 3'd2, 3'd2);
    read_back("R2 neighbour untouched", 3'd2, 3'd5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule